// File: doc/BRIEF.md
# Programmable Serial Clock Generator

This block produces the serial clock for a flash controller from the system clock. An up-counter runs from zero to a programmable wrap value and back to zero, so one serial period lasts wrap+1 system cycles. A second compare value splits each period: counts zero through the high compare drive the line to its active level, and the remaining counts drive it to its idle level. A bypass bit replaces the counter with the system clock itself for divide-by-one operation.

Alongside the clock it gives a transfer sequencer two strobes, each one system cycle wide. The sample strobe marks the start of the active phase and the shift strobe marks the return to idle. A two-bit gating mode ties the clock to the chip-select-active input: it can stop at once, run on for one or two extra periods, or run freely. A dummy-gate request hides pulses and strobes without disturbing the period count. Divider and bypass settings are held in shadow registers that reload only while stopped or at the end of a period, so a setting change never cuts a pulse short.

The controller has three named states. STOPPED holds the counter at zero. RUNNING counts while chip select is active. RUNOUT finishes the remaining periods after chip select drops. The transitions are START (STOPPED to RUNNING when chip select is active or the mode is free-running), HALT (RUNNING or RUNOUT to STOPPED in mode 0 once chip select is low), LINGER (RUNNING to RUNOUT in modes 1 and 2 once chip select is low), RESUME (RUNOUT to RUNNING when chip select returns or the mode becomes free-running), and DRAIN (RUNOUT to STOPPED at the end of the last run-on period).

Top module: `spiclk_gen`

## Requirements
- R1: With bypass off and a wrap value N of at least 1, the serial clock period is N+1 system cycles.
- R2: Within each divided period, counts 0 through H (the high compare, below N) are at the active level and counts H+1 through N are at the idle level, so the active time is H+1 cycles.
- R3: With bypass on and the clock running, sclk follows the system clock (active level while the system clock is high, idle level while it is low), and both strobes are high on every cycle.
- R4: The idle level of sclk equals the idle_high pin (1 means high, 0 means low), and the active level is its inverse.
- R5: gate_mode 0 stops the clock on the cycle after an edge that samples cs_active low. While stopped, sclk sits at the idle level and both strobes stay low.
- R6: gate_mode 1 or 2 keeps the clock running after chip select drops. The clock completes the current period, then runs 1 or 2 further full periods, then stops.
- R7: gate_mode 3 keeps the clock running whatever the value of cs_active.
- R8: While dummy_gate is high, sclk is at the idle level and both strobes are low on that same cycle. The period counter keeps advancing.
- R9: In divided mode, sample_stb is high for exactly the count-0 cycle and shift_stb for exactly the count-H+1 cycle, giving one of each per period.
- R10: New wrap, high compare and bypass values take effect only while stopped or at a period boundary. A change made mid-period leaves that period at its old length.
- R11: During and after reset the clock is stopped, sclk is at the idle level and both strobes are low.
- R12: From the stopped state, the first cycle after the edge that samples a start condition is count 0, so the active level and sample_stb appear together on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_wrap | input | DIV_W | Wrap value N; the period is N+1 cycles |
| div_high | input | DIV_W | High compare H; last count of the active phase |
| bypass | input | 1 | 1 selects divide-by-one pass-through |
| gate_mode | input | 2 | 0 stop with CS, 1 or 2 periods of run-on, 3 free-running |
| idle_high | input | 1 | Idle level of sclk (1 high, 0 low) |
| cs_active | input | 1 | Chip select is active |
| dummy_gate | input | 1 | Suppress pulses and strobes this cycle |
| sclk | output | 1 | Serial clock |
| shift_stb | output | 1 | One-cycle strobe at the turn to idle level |
| sample_stb | output | 1 | One-cycle strobe at the turn to active level |

## Verification
The divider is tried with wrap/high pairs 3/1, 4/1 and 7/3 at both idle levels. These pairs separate an off-by-one in the wrap compare from one in the high compare, and they show whether polarity is applied to the idle phase or the active phase. A divider change made right after a sample strobe shows whether the reload waits for the boundary. Dropping chip select just after a sample strobe in each gating mode gives a fixed count of run-on pulses, which separates modes 0, 1 and 2. Free-running with chip select low, a dummy window, and bypass checked at both system clock levels cover the remaining paths.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;

    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_RUNNING = 2'd1,
        ST_RUNOUT  = 2'd2
    } spiclk_state_e;

    typedef enum logic [1:0] {
        GATE_WITH_CS = 2'd0,
        GATE_RUNON1  = 2'd1,
        GATE_RUNON2  = 2'd2,
        GATE_FREE    = 2'd3
    } spiclk_gate_e;

    localparam int GATE_W = 2;

endpackage

// File: rtl/spiclk_shadow.sv
module spiclk_shadow #(
    parameter int DIV_W     = 8,
    parameter bit BYPASS_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_wrap,
    input  logic [DIV_W-1:0] div_high,
    input  logic             bypass,
    output logic [DIV_W-1:0] wrap_q,
    output logic [DIV_W-1:0] high_q,
    output logic             byp_q,
    output logic [DIV_W-1:0] wrap_eff
);

    localparam logic [DIV_W-1:0] WRAP_RST = DIV_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wrap_q <= WRAP_RST;
            high_q <= '0;
        end else if (load) begin
            wrap_q <= div_wrap;
            high_q <= div_high;
        end
    end

    generate
        if (BYPASS_EN) begin : g_byp
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    byp_q <= 1'b0;
                else if (load) byp_q <= bypass;
            end
        end else begin : g_nobyp
            logic unused_byp;
            assign unused_byp = bypass;
            assign byp_q      = 1'b0;
        end
    endgenerate

    // in bypass every system cycle is a full period
    assign wrap_eff = byp_q ? '0 : wrap_q;

endmodule

// File: rtl/spiclk_ticker.sv
module spiclk_ticker #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [DIV_W-1:0] wrap_eff,
    output logic [DIV_W-1:0] cnt_q,
    output logic             period_end
);

    assign period_end = run && (cnt_q == wrap_eff);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || clear || period_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/spiclk_fsm.sv
module spiclk_fsm
    import spiclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic [GATE_W-1:0] gate_mode,
    input  logic              period_end,
    output spiclk_state_e     state_q,
    output logic              run,
    output logic              cnt_clear,
    output logic              load_cfg
);

    spiclk_state_e     state_nxt;
    logic [GATE_W-1:0] runon_q;
    logic [GATE_W-1:0] runon_nxt;
    spiclk_gate_e      mode;
    logic              keep_going;

    assign mode       = spiclk_gate_e'(gate_mode);
    assign keep_going = cs_active || (mode == GATE_FREE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOPPED;
            runon_q <= '0;
        end else begin
            state_q <= state_nxt;
            runon_q <= runon_nxt;
        end
    end

    // transitions: START, HALT, LINGER, RESUME, DRAIN
    always_comb begin
        state_nxt = state_q;
        runon_nxt = runon_q;
        unique case (state_q)
            ST_STOPPED: begin
                if (keep_going) state_nxt = ST_RUNNING;          // START
            end
            ST_RUNNING: begin
                if (!keep_going) begin
                    if (mode == GATE_WITH_CS) begin
                        state_nxt = ST_STOPPED;                  // HALT
                    end else begin
                        state_nxt = ST_RUNOUT;                   // LINGER
                        runon_nxt = gate_mode;
                    end
                end
            end
            ST_RUNOUT: begin
                if (keep_going) begin
                    state_nxt = ST_RUNNING;                      // RESUME
                end else if (mode == GATE_WITH_CS) begin
                    state_nxt = ST_STOPPED;                      // HALT
                end else if (period_end) begin
                    if (runon_q == '0) state_nxt = ST_STOPPED;   // DRAIN
                    else               runon_nxt = runon_q - GATE_W'(1);
                end
            end
            default: state_nxt = ST_STOPPED;
        endcase
    end

    // outputs
    always_comb begin
        run       = (state_q != ST_STOPPED);
        cnt_clear = (state_nxt == ST_STOPPED);
        load_cfg  = (state_q == ST_STOPPED) || period_end;
    end

endmodule

// File: rtl/spiclk_outgen.sv
module spiclk_outgen #(
    parameter int DIV_W     = 8,
    parameter bit BYPASS_EN = 1'b1
) (
    input  logic             clk,
    input  logic             run,
    input  logic             dummy_gate,
    input  logic             idle_high,
    input  logic             byp_q,
    input  logic [DIV_W-1:0] cnt_q,
    input  logic [DIV_W-1:0] high_q,
    input  logic [DIV_W-1:0] wrap_q,
    output logic             sclk,
    output logic             shift_stb,
    output logic             sample_stb
);

    logic visible;
    logic div_active;
    logic div_shift;
    logic div_sample;
    logic has_idle_phase;

    assign visible        = run && !dummy_gate;
    assign has_idle_phase = (high_q < wrap_q);
    assign div_active     = (cnt_q <= high_q);
    assign div_sample     = (cnt_q == '0);
    assign div_shift      = has_idle_phase && (cnt_q == high_q + DIV_W'(1));

    generate
        if (BYPASS_EN) begin : g_byp
            always_comb begin
                if (!visible) begin
                    sclk       = idle_high;
                    shift_stb  = 1'b0;
                    sample_stb = 1'b0;
                end else if (byp_q) begin
                    sclk       = clk ^ idle_high;
                    shift_stb  = 1'b1;
                    sample_stb = 1'b1;
                end else begin
                    sclk       = div_active ? ~idle_high : idle_high;
                    shift_stb  = div_shift;
                    sample_stb = div_sample;
                end
            end
        end else begin : g_nobyp
            logic unused_in;
            assign unused_in  = clk ^ byp_q;
            assign sclk       = (visible && div_active) ? ~idle_high : idle_high;
            assign shift_stb  = visible && div_shift;
            assign sample_stb = visible && div_sample;
        end
    endgenerate

endmodule

// File: rtl/spiclk_gen.sv
module spiclk_gen
    import spiclk_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter bit BYPASS_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_wrap,
    input  logic [DIV_W-1:0] div_high,
    input  logic             bypass,
    input  logic [1:0]       gate_mode,
    input  logic             idle_high,
    input  logic             cs_active,
    input  logic             dummy_gate,
    output logic             sclk,
    output logic             shift_stb,
    output logic             sample_stb
);

    spiclk_state_e    state_q;
    logic             run;
    logic             cnt_clear;
    logic             load_cfg;
    logic             period_end;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] wrap_q;
    logic [DIV_W-1:0] high_q;
    logic [DIV_W-1:0] wrap_eff;
    logic             byp_q;

    spiclk_shadow #(.DIV_W(DIV_W), .BYPASS_EN(BYPASS_EN)) u_shadow (
        .clk(clk), .rst_n(rst_n), .load(load_cfg),
        .div_wrap(div_wrap), .div_high(div_high), .bypass(bypass),
        .wrap_q(wrap_q), .high_q(high_q), .byp_q(byp_q), .wrap_eff(wrap_eff)
    );

    spiclk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .gate_mode(gate_mode),
        .period_end(period_end), .state_q(state_q), .run(run),
        .cnt_clear(cnt_clear), .load_cfg(load_cfg)
    );

    spiclk_ticker #(.DIV_W(DIV_W)) u_ticker (
        .clk(clk), .rst_n(rst_n), .run(run), .clear(cnt_clear),
        .wrap_eff(wrap_eff), .cnt_q(cnt_q), .period_end(period_end)
    );

    spiclk_outgen #(.DIV_W(DIV_W), .BYPASS_EN(BYPASS_EN)) u_out (
        .clk(clk), .run(run), .dummy_gate(dummy_gate), .idle_high(idle_high),
        .byp_q(byp_q), .cnt_q(cnt_q), .high_q(high_q), .wrap_q(wrap_q),
        .sclk(sclk), .shift_stb(shift_stb), .sample_stb(sample_stb)
    );

endmodule

// File: rtl/spiclk_gen_chk.sv
module spiclk_gen_chk
    import spiclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       gate_mode,
    input logic             cs_active,
    input logic             dummy_gate,
    input logic             idle_high,
    input logic             sclk,
    input logic             shift_stb,
    input logic             sample_stb,
    input spiclk_state_e    st,
    input logic [DIV_W-1:0] cnt,
    input logic [DIV_W-1:0] wrap_q,
    input logic             byp_q
);

    // R5
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOPPED) |-> (sclk == idle_high && !shift_stb && !sample_stb));

    // R5
    halt_on_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_mode == 2'd0 && !cs_active) |=> (st == ST_STOPPED));

    // R7
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_mode == 2'd3) |=> (st != ST_STOPPED));

    // R8
    dummy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dummy_gate |-> (!shift_stb && !sample_stb));

    // R1
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byp_q |-> (cnt <= wrap_q));

    // R9
    sample_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && !byp_q && wrap_q != '0) |=> !sample_stb);

    // R9
    strobe_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byp_q |-> !(shift_stb && sample_stb));

endmodule

bind spiclk_gen spiclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .gate_mode(gate_mode), .cs_active(cs_active),
    .dummy_gate(dummy_gate), .idle_high(idle_high), .sclk(sclk),
    .shift_stb(shift_stb), .sample_stb(sample_stb), .st(state_q),
    .cnt(cnt_q), .wrap_q(wrap_q), .byp_q(byp_q)
);

// File: tb/test_spiclk_gen.sv
`timescale 1ns/1ps
module test_spiclk_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_wrap = 8'd3;
    logic [7:0] div_high = 8'd1;
    logic       bypass = 1'b0;
    logic [1:0] gate_mode = 2'd0;
    logic       idle_high = 1'b0;
    logic       cs_active = 1'b0;
    logic       dummy_gate = 1'b0;
    logic       sclk, shift_stb, sample_stb;

    int    errors = 0;
    int    checks = 0;
    string tag = "R11";

    always #5 clk = ~clk;

    spiclk_gen i_spiclk_gen (
        .clk(clk), .rst_n(rst_n), .div_wrap(div_wrap), .div_high(div_high),
        .bypass(bypass), .gate_mode(gate_mode), .idle_high(idle_high),
        .cs_active(cs_active), .dummy_gate(dummy_gate), .sclk(sclk),
        .shift_stb(shift_stb), .sample_stb(sample_stb)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference: state 0 stopped, 1 running, 2 run-on
    int m_st = 0, m_cnt = 0, m_lo = 1, m_hi = 0, m_byp = 0, m_tl = 0;

    always @(posedge clk) begin
        int lo_eff, nst, ntl, ncnt;
        bit go, wrapn;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_lo = 1; m_hi = 0; m_byp = 0; m_tl = 0;
        end else begin
            lo_eff = m_byp ? 0 : m_lo;
            wrapn  = (m_st != 0) && (m_cnt == lo_eff);
            go     = cs_active || (gate_mode == 2'd3);
            nst = m_st; ntl = m_tl;
            if (m_st == 0) begin
                if (go) nst = 1;
            end else if (m_st == 1) begin
                if (!go) begin
                    if (gate_mode == 2'd0) nst = 0;
                    else begin nst = 2; ntl = int'(gate_mode); end
                end
            end else begin
                if (go) nst = 1;
                else if (gate_mode == 2'd0) nst = 0;
                else if (wrapn) begin
                    if (m_tl == 0) nst = 0; else ntl = m_tl - 1;
                end
            end
            if (m_st == 0 || nst == 0 || wrapn) ncnt = 0; else ncnt = m_cnt + 1;
            if (m_st == 0 || wrapn) begin
                m_lo = int'(div_wrap); m_hi = int'(div_high); m_byp = int'(bypass);
            end
            m_st = nst; m_tl = ntl; m_cnt = ncnt;
        end
        #2;
        begin
            bit vis;
            int e_sclk, e_sh, e_sa;
            vis = (m_st != 0) && !dummy_gate;
            if (!vis) begin
                e_sclk = idle_high; e_sh = 0; e_sa = 0;
            end else if (m_byp != 0) begin
                e_sclk = !idle_high; e_sh = 1; e_sa = 1;
            end else begin
                e_sclk = (m_cnt <= m_hi) ? !idle_high : idle_high;
                e_sa   = (m_cnt == 0);
                e_sh   = (m_hi < m_lo) && (m_cnt == m_hi + 1);
            end
            check(tag, int'(sclk), e_sclk, "model sclk");
            check(tag, int'(shift_stb), e_sh, "model shift_stb");
            check(tag, int'(sample_stb), e_sa, "model sample_stb");
        end
    end

    task automatic tick();
        @(posedge clk); #3;
    endtask

    task automatic wait_sample();
        for (int i = 0; i < 300; i++) begin
            tick();
            if (sample_stb) return;
        end
    endtask

    task automatic measure(input string req, input int exp_per, input int exp_hi);
        int n, hi, sh;
        wait_sample();
        n = 1; hi = (sclk != idle_high); sh = shift_stb;
        for (int i = 0; i < 300; i++) begin
            tick();
            if (sample_stb) break;
            n++;
            if (sclk != idle_high) hi++;
            if (shift_stb) sh++;
        end
        check(req, n, exp_per, "period cycles");
        check(req, hi, exp_hi, "active cycles");
        check("R9", sh, 1, "shift strobes per period");
    endtask

    task automatic count_samples(input int cycles, output int ns);
        ns = 0;
        for (int i = 0; i < cycles; i++) begin
            tick();
            if (sample_stb) ns++;
        end
    endtask

    initial begin
        int ns, n;
        repeat (3) @(negedge clk);
        check("R11", int'(sclk), 0, "sclk in reset");
        check("R11", int'(sample_stb | shift_stb), 0, "strobes in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", int'(sclk), 0, "sclk after reset");

        tag = "R12";
        cs_active = 1'b1;
        tick();
        check("R12", int'(sample_stb), 1, "sample on first run cycle");
        check("R12", int'(sclk), 1, "active on first run cycle");

        tag = "R1";
        measure("R1", 4, 2);
        @(negedge clk); div_wrap = 8'd4; div_high = 8'd1;
        tag = "R2";
        measure("R2", 5, 2);
        @(negedge clk); idle_high = 1'b1; div_wrap = 8'd7; div_high = 8'd3;
        tag = "R4";
        measure("R4", 8, 4);

        tag = "R10";
        wait_sample();
        @(negedge clk); div_wrap = 8'd3; div_high = 8'd1;
        n = 1;
        for (int i = 0; i < 50; i++) begin
            tick();
            if (sample_stb) break;
            n++;
        end
        check("R10", n, 8, "old period kept after mid-period change");
        measure("R10", 4, 2);

        tag = "R6";
        @(negedge clk); idle_high = 1'b0; gate_mode = 2'd1;
        wait_sample();
        @(negedge clk); cs_active = 1'b0;
        count_samples(30, ns);
        check("R6", ns, 1, "run-on periods mode 1");
        check("R6", int'(sclk), 0, "idle after mode 1 run-on");
        @(negedge clk); cs_active = 1'b1; gate_mode = 2'd2;
        wait_sample();
        @(negedge clk); cs_active = 1'b0;
        count_samples(30, ns);
        check("R6", ns, 2, "run-on periods mode 2");

        tag = "R5";
        @(negedge clk); cs_active = 1'b1; gate_mode = 2'd0;
        wait_sample();
        @(negedge clk); cs_active = 1'b0;
        count_samples(20, ns);
        check("R5", ns, 0, "no pulses after CS drop in mode 0");
        check("R5", int'(sclk), 0, "sclk idle when stopped");

        tag = "R7";
        @(negedge clk); gate_mode = 2'd3;
        count_samples(20, ns);
        check("R7", int'(ns >= 4), 1, "free running with CS low");

        tag = "R8";
        @(negedge clk); dummy_gate = 1'b1;
        n = 0;
        for (int i = 0; i < 12; i++) begin
            tick();
            if (sample_stb || shift_stb || sclk) n++;
        end
        check("R8", n, 0, "cycles with visible activity under dummy gate");
        @(negedge clk); dummy_gate = 1'b0;

        tag = "R3";
        @(negedge clk); bypass = 1'b1;
        repeat (6) tick();
        n = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #3;
            if (sclk === 1'b1 && sample_stb && shift_stb) n++;
            @(negedge clk); #3;
            if (sclk === 1'b0) n++;
        end
        check("R3", n, 16, "bypass follows system clock");

        @(negedge clk); bypass = 1'b0; gate_mode = 2'd0;
        repeat (10) tick();
        tag = "R5";
        check("R5", int'(sclk), 0, "final stopped level");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule